// File: doc/BRIEF.md
# Multi-Layer Road-Matching Track Linker

The linker serves one azimuthal sector of a four-layer axial tracking chamber. For each event it takes a fired-pixel map from every layer, where each fired pixel also carries a slope bin. It then tests those maps against a table of roads. A road names one pixel in each layer and, for each layer, either one required slope bin or "any slope". When a road's requirement holds in all four layers, the road is a track candidate. The candidate's momentum code and phi code are not computed from the hits: they are taken from fields stored in the road entry itself.

The table sits in synchronous RAM. It is scanned one road per clock, so every event costs a fixed number of cycles. When several roads match, the linker reports the one with the highest momentum code, and the lowest road index breaks ties. It also reports how many roads qualified, and gives a one-cycle done pulse. A minimum momentum code set at build time drops roads below it. Software loads the table through a write port. While that port's load enable is high, the scan is held.

Top module: `road_linker`

## Requirements
- R1: Bit p*S+s of a layer input means that pixel p fired with slope bin s. S is NSLP_IN for layers 0 and 1 (inputs `pix_l0`, `pix_l1`, innermost first) and NSLP_OUT for layers 2 and 3. A road matches only when, in every layer, its pixel has its slope bit set, or, if the road's slope code is 7, when any slope bit of that pixel is set.
- R2: A specific slope code at or above the slope count of its layer (3 and up on the inner layers, 5 and 6 on the outer layers) never matches.
- R3: A matching road whose momentum code is below PT_MIN is ignored. It is neither reported nor counted.
- R4: Among qualifying matches, the outputs `trk_pt`, `trk_phi` and `trk_road` report the road with the highest momentum code. On equal codes they report the lowest index.
- R5: `trk_count` equals the number of qualifying matching roads in the event.
- R6: If no road qualifies, done is raised with `trk_valid` low, and `trk_count`, `trk_pt`, `trk_phi` and `trk_road` are all zero.
- R7: If load enable stays low, done is high for exactly one cycle. That cycle begins NROAD+2 rising edges after the edge that accepted the strobe.
- R8: A strobe is accepted only when the block is idle and load enable is low. A strobe during a scan, or while load enable is high, has no effect. The input maps are captured at the accepting edge only.
- R9: While load enable is high, the scan is frozen. The result does not change, and done is delayed by exactly the number of frozen edges.
- R10: When load enable and write enable are both high, the road word is written at `ld_addr`. The road word is packed with layer k's pixel index in bits [k*LW +: PIXW], layer k's slope code in the next 3 bits (LW = PIXW+3), then the momentum code at [4*LW +: PT_W], then the phi code above it.
- R11: Reset clears done and all result outputs. Result outputs change only in the cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_stb | input | 1 | Start an event with the current pixel maps |
| pix_l0 | input | NPIX*NSLP_IN | Layer 0 pixel/slope map |
| pix_l1 | input | NPIX*NSLP_IN | Layer 1 pixel/slope map |
| pix_l2 | input | NPIX*NSLP_OUT | Layer 2 pixel/slope map |
| pix_l3 | input | NPIX*NSLP_OUT | Layer 3 pixel/slope map |
| ld_en | input | 1 | Table load mode; holds the scan |
| ld_we | input | 1 | Table write strobe |
| ld_addr | input | AW | Road index to write |
| ld_road | input | RW | Packed road word |
| done | output | 1 | One-cycle end-of-scan pulse |
| trk_valid | output | 1 | A qualifying road was found |
| trk_pt | output | PT_W | Momentum code of the best road |
| trk_phi | output | PHI_W | Phi code of the best road |
| trk_road | output | AW | Index of the best road |
| trk_count | output | CW | Number of qualifying roads |

## Verification
Some properties are checked by assertions on every cycle:
- done never lasts longer than one cycle.
- done comes exactly NROAD+2 unfrozen edges after an accepted strobe.
- Result outputs move only together with done.
- An empty result carries a zero count, a non-empty result carries a nonzero count, and a reported momentum code is at least PT_MIN.
- An accepted strobe always starts a scan.

Other behaviour can only be shown by the bench's scenarios, which compare against an arithmetic model of the table:
- the per-layer pixel and slope match rule, including the "any slope" code and codes out of range for a layer;
- the choice of the winning road, including the lowest-index tie break;
- freezing under load enable;
- strobes that arrive during a scan or during a load and must be ignored.

// File: rtl/lk_pkg.sv
package lk_pkg;
  localparam int NLAYER = 4;
  localparam int SLW = 3;
  localparam logic [SLW-1:0] SLP_ANY = 3'd7;

  typedef enum logic [1:0] {SC_IDLE, SC_SCAN, SC_DRAIN} scan_st_t;
endpackage

// File: rtl/lk_layer_match.sv
module lk_layer_match
  import lk_pkg::*;
#(
  parameter int NPIX   = 12,
  parameter int PIXW   = 4,
  parameter int STRIDE = 5,
  parameter int NSLP   = 5
) (
  input  logic [NPIX*STRIDE-1:0] vec,
  input  logic [PIXW-1:0]        pix,
  input  logic [SLW-1:0]         slp,
  output logic                   hit
);
  // A pixel matches on its own slope bin, or on any bin when the code is "any".
  always_comb begin
    hit = 1'b0;
    for (int p = 0; p < NPIX; p++) begin
      if (pix == PIXW'(p)) begin
        for (int s = 0; s < NSLP; s++) begin
          if (vec[p*STRIDE+s] && (slp == SLP_ANY || slp == SLW'(s)))
            hit = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lk_road_match.sv
module lk_road_match
  import lk_pkg::*;
#(
  parameter int NPIX     = 12,
  parameter int NSLP_IN  = 3,
  parameter int NSLP_OUT = 5,
  parameter int PT_W     = 6,
  parameter int PHI_W    = 6,
  localparam int PIXW    = $clog2(NPIX),
  localparam int LW      = PIXW + SLW,
  localparam int VW      = NPIX * NSLP_OUT,
  localparam int RW      = NLAYER * LW + PT_W + PHI_W
) (
  input  logic [NLAYER-1:0][VW-1:0] cap,
  input  logic [RW-1:0]             road,
  output logic                      hit,
  output logic [PT_W-1:0]           pt,
  output logic [PHI_W-1:0]          phi
);
  logic [NLAYER-1:0] lh;

  for (genvar k = 0; k < NLAYER; k++) begin : g_lay
    localparam int NS = (k < 2) ? NSLP_IN : NSLP_OUT;
    lk_layer_match #(
      .NPIX(NPIX), .PIXW(PIXW), .STRIDE(NSLP_OUT), .NSLP(NS)
    ) u_lm (
      .vec(cap[k]),
      .pix(road[k*LW +: PIXW]),
      .slp(road[k*LW+PIXW +: SLW]),
      .hit(lh[k])
    );
  end

  assign hit = &lh;
  assign pt  = road[NLAYER*LW +: PT_W];
  assign phi = road[NLAYER*LW+PT_W +: PHI_W];
endmodule

// File: rtl/lk_road_table.sv
module lk_road_table #(
  parameter int DEPTH = 1200,
  parameter int AW    = 11,
  parameter int W     = 40
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < DEPTH))
      mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re)
      rdata <= mem[raddr];
  end
endmodule

// File: rtl/lk_best.sv
module lk_best #(
  parameter int AW     = 11,
  parameter int CW     = 11,
  parameter int PT_W   = 6,
  parameter int PHI_W  = 6,
  parameter int PT_MIN = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             start,
  input  logic             cmp_vld,
  input  logic             cmp_hit,
  input  logic [PT_W-1:0]  cmp_pt,
  input  logic [PHI_W-1:0] cmp_phi,
  input  logic [AW-1:0]    cmp_idx,
  input  logic             fin,
  output logic             done,
  output logic             trk_valid,
  output logic [PT_W-1:0]  trk_pt,
  output logic [PHI_W-1:0] trk_phi,
  output logic [AW-1:0]    trk_road,
  output logic [CW-1:0]    trk_count
);
  logic             b_vld;
  logic [PT_W-1:0]  b_pt;
  logic [PHI_W-1:0] b_phi;
  logic [AW-1:0]    b_idx;
  logic [CW-1:0]    b_cnt;
  logic             qual;

  assign qual = cmp_vld && cmp_hit && (int'(cmp_pt) >= PT_MIN);

  // Running best; strict greater-than keeps the earlier (lower) index on ties.
  always_ff @(posedge clk) begin
    if (rst || (run && start)) begin
      b_vld <= 1'b0;
      b_pt  <= '0;
      b_phi <= '0;
      b_idx <= '0;
      b_cnt <= '0;
    end else if (run && qual) begin
      b_cnt <= b_cnt + CW'(1);
      if (!b_vld || cmp_pt > b_pt) begin
        b_vld <= 1'b1;
        b_pt  <= cmp_pt;
        b_phi <= cmp_phi;
        b_idx <= cmp_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      trk_valid <= 1'b0;
      trk_pt    <= '0;
      trk_phi   <= '0;
      trk_road  <= '0;
      trk_count <= '0;
    end else begin
      done <= run && fin;
      if (run && fin) begin
        trk_valid <= b_vld;
        trk_pt    <= b_pt;
        trk_phi   <= b_phi;
        trk_road  <= b_idx;
        trk_count <= b_cnt;
      end
    end
  end
endmodule

// File: rtl/road_linker.sv
module road_linker
  import lk_pkg::*;
#(
  parameter int NPIX     = 12,
  parameter int NSLP_IN  = 3,
  parameter int NSLP_OUT = 5,
  parameter int NROAD    = 1200,
  parameter int PT_W     = 6,
  parameter int PHI_W    = 6,
  parameter int PT_MIN   = 1,
  localparam int PIXW    = $clog2(NPIX),
  localparam int LW      = PIXW + SLW,
  localparam int VW      = NPIX * NSLP_OUT,
  localparam int RW      = NLAYER * LW + PT_W + PHI_W,
  localparam int AW      = $clog2(NROAD),
  localparam int CW      = $clog2(NROAD + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    evt_stb,
  input  logic [NPIX*NSLP_IN-1:0]  pix_l0,
  input  logic [NPIX*NSLP_IN-1:0]  pix_l1,
  input  logic [NPIX*NSLP_OUT-1:0] pix_l2,
  input  logic [NPIX*NSLP_OUT-1:0] pix_l3,
  input  logic                    ld_en,
  input  logic                    ld_we,
  input  logic [AW-1:0]           ld_addr,
  input  logic [RW-1:0]           ld_road,
  output logic                    done,
  output logic                    trk_valid,
  output logic [PT_W-1:0]         trk_pt,
  output logic [PHI_W-1:0]        trk_phi,
  output logic [AW-1:0]           trk_road,
  output logic [CW-1:0]           trk_count
);
  localparam logic [AW-1:0] LAST = AW'(NROAD - 1);

  scan_st_t                 state;
  logic                     run, accept, scan_busy;
  logic [AW-1:0]            raddr, rd_idx;
  logic                     rd_vld, last_q;
  logic [RW-1:0]            rdata;
  logic [NLAYER-1:0][VW-1:0] pad, cap;
  logic                     m_hit;
  logic [PT_W-1:0]          m_pt;
  logic [PHI_W-1:0]         m_phi;

  assign run       = !ld_en;
  assign accept    = run && evt_stb && (state == SC_IDLE);
  assign scan_busy = (state != SC_IDLE);

  // Lay all layers out with the outer-layer stride; inner slope bins are zero-padded.
  always_comb begin
    pad = '0;
    for (int p = 0; p < NPIX; p++) begin
      for (int s = 0; s < NSLP_IN; s++) begin
        pad[0][p*NSLP_OUT+s] = pix_l0[p*NSLP_IN+s];
        pad[1][p*NSLP_OUT+s] = pix_l1[p*NSLP_IN+s];
      end
    end
    pad[2] = pix_l2;
    pad[3] = pix_l3;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SC_IDLE;
      raddr  <= '0;
      rd_idx <= '0;
      rd_vld <= 1'b0;
      last_q <= 1'b0;
      cap    <= '0;
    end else if (run) begin
      rd_vld <= (state == SC_SCAN);
      rd_idx <= raddr;
      last_q <= rd_vld && (rd_idx == LAST);
      case (state)
        SC_IDLE: begin
          if (evt_stb) begin
            cap   <= pad;
            raddr <= '0;
            state <= SC_SCAN;
          end
        end
        SC_SCAN: begin
          if (raddr == LAST) begin
            raddr <= '0;
            state <= SC_DRAIN;
          end else begin
            raddr <= raddr + AW'(1);
          end
        end
        SC_DRAIN: begin
          if (last_q)
            state <= SC_IDLE;
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  lk_road_table #(.DEPTH(NROAD), .AW(AW), .W(RW)) u_tab (
    .clk  (clk),
    .we   (ld_en && ld_we),
    .waddr(ld_addr),
    .wdata(ld_road),
    .re   (run && (state == SC_SCAN)),
    .raddr(raddr),
    .rdata(rdata)
  );

  lk_road_match #(
    .NPIX(NPIX), .NSLP_IN(NSLP_IN), .NSLP_OUT(NSLP_OUT),
    .PT_W(PT_W), .PHI_W(PHI_W)
  ) u_match (
    .cap (cap),
    .road(rdata),
    .hit (m_hit),
    .pt  (m_pt),
    .phi (m_phi)
  );

  lk_best #(
    .AW(AW), .CW(CW), .PT_W(PT_W), .PHI_W(PHI_W), .PT_MIN(PT_MIN)
  ) u_best (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .start    (accept),
    .cmp_vld  (rd_vld),
    .cmp_hit  (m_hit),
    .cmp_pt   (m_pt),
    .cmp_phi  (m_phi),
    .cmp_idx  (rd_idx),
    .fin      (last_q),
    .done     (done),
    .trk_valid(trk_valid),
    .trk_pt   (trk_pt),
    .trk_phi  (trk_phi),
    .trk_road (trk_road),
    .trk_count(trk_count)
  );
endmodule

// File: rtl/lk_checker.sv
module lk_checker #(
  parameter int NROAD  = 1200,
  parameter int PT_W   = 6,
  parameter int PHI_W  = 6,
  parameter int PT_MIN = 1,
  parameter int AW     = 11,
  parameter int CW     = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_stb,
  input logic             ld_en,
  input logic             busy,
  input logic             done,
  input logic             trk_valid,
  input logic [PT_W-1:0]  trk_pt,
  input logic [PHI_W-1:0] trk_phi,
  input logic [AW-1:0]    trk_road,
  input logic [CW-1:0]    trk_count
);
  localparam int LTW = $clog2(NROAD + 4) + 1;

  logic           acc;
  logic [LTW-1:0] lat;

  assign acc = evt_stb && !ld_en && !busy;

  // Unfrozen edges since the accepting edge.
  always_ff @(posedge clk) begin
    if (rst)
      lat <= '0;
    else if (acc)
      lat <= '0;
    else if (!ld_en && lat != '1)
      lat <= lat + LTW'(1);
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_budget_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (32'(lat) == NROAD + 2));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> !done);

  assert_start_R8: assert property (@(posedge clk) disable iff (rst)
    acc |=> busy);

  assert_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (done && trk_valid) |-> (int'(trk_pt) >= PT_MIN));

  assert_count_R5: assert property (@(posedge clk) disable iff (rst)
    (done && trk_valid) |-> (trk_count != '0));

  assert_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !trk_valid) |-> (trk_count == '0 && trk_pt == '0 && trk_phi == '0));

  assert_road_range_R4: assert property (@(posedge clk) disable iff (rst)
    (done && trk_valid) |-> (32'(trk_road) < NROAD));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable({trk_valid, trk_pt, trk_phi, trk_road, trk_count}) |-> done);
endmodule

bind road_linker lk_checker #(
  .NROAD(NROAD), .PT_W(PT_W), .PHI_W(PHI_W), .PT_MIN(PT_MIN), .AW(AW), .CW(CW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .evt_stb  (evt_stb),
  .ld_en    (ld_en),
  .busy     (scan_busy),
  .done     (done),
  .trk_valid(trk_valid),
  .trk_pt   (trk_pt),
  .trk_phi  (trk_phi),
  .trk_road (trk_road),
  .trk_count(trk_count)
);

// File: tb/sim_road_linker.sv
`timescale 1ns/1ps
module sim_road_linker;
  localparam int NPIX = 4, NSLP_IN = 3, NSLP_OUT = 5, NROAD = 8;
  localparam int PT_W = 3, PHI_W = 3, PT_MIN = 2;
  localparam int LW = 5, RW = 26, AW = 3, CW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, evt_stb, ld_en, ld_we;
  logic [11:0] v0, v1;
  logic [19:0] v2, v3;
  logic [AW-1:0] ld_addr;
  logic [RW-1:0] ld_road;
  logic done, trk_valid;
  logic [PT_W-1:0] trk_pt;
  logic [PHI_W-1:0] trk_phi;
  logic [AW-1:0] trk_road;
  logic [CW-1:0] trk_count;

  road_linker #(
    .NPIX(NPIX), .NSLP_IN(NSLP_IN), .NSLP_OUT(NSLP_OUT), .NROAD(NROAD),
    .PT_W(PT_W), .PHI_W(PHI_W), .PT_MIN(PT_MIN)
  ) u0 (
    .clk(clk), .rst(rst), .evt_stb(evt_stb),
    .pix_l0(v0), .pix_l1(v1), .pix_l2(v2), .pix_l3(v3),
    .ld_en(ld_en), .ld_we(ld_we), .ld_addr(ld_addr), .ld_road(ld_road),
    .done(done), .trk_valid(trk_valid), .trk_pt(trk_pt), .trk_phi(trk_phi),
    .trk_road(trk_road), .trk_count(trk_count)
  );

  int n_run = 0, n_fail = 0;
  int rp [NROAD][4];
  int rs [NROAD][4];
  int rpt [NROAD];
  int rphi [NROAD];
  int e_v, e_pt, e_phi, e_idx, e_cnt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nsl(input int k);
    return (k < 2) ? NSLP_IN : NSLP_OUT;
  endfunction

  function automatic bit bitof(input int k, input int b);
    case (k)
      0: return v0[b];
      1: return v1[b];
      2: return v2[b];
      default: return v3[b];
    endcase
  endfunction

  task automatic setbit(input int k, input int b);
    case (k)
      0: v0[b] = 1'b1;
      1: v1[b] = 1'b1;
      2: v2[b] = 1'b1;
      default: v3[b] = 1'b1;
    endcase
  endtask

  function automatic bit road_hits(input int i);
    for (int k = 0; k < 4; k++) begin
      bit lh = 1'b0;
      for (int s = 0; s < nsl(k); s++)
        if (bitof(k, rp[i][k]*nsl(k)+s) && (rs[i][k] == 7 || rs[i][k] == s)) lh = 1'b1;
      if (!lh) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic model();
    e_v = 0; e_pt = 0; e_phi = 0; e_idx = 0; e_cnt = 0;
    for (int i = 0; i < NROAD; i++) begin
      if (road_hits(i) && rpt[i] >= PT_MIN) begin
        e_cnt++;
        if (e_v == 0 || rpt[i] > e_pt) begin
          e_v = 1; e_pt = rpt[i]; e_phi = rphi[i]; e_idx = i;
        end
      end
    end
  endtask

  function automatic logic [RW-1:0] pack(input int i);
    logic [RW-1:0] w = '0;
    for (int k = 0; k < 4; k++) begin
      w[k*LW +: 2]   = 2'(rp[i][k]);
      w[k*LW+2 +: 3] = 3'(rs[i][k]);
    end
    w[20 +: 3] = 3'(rpt[i]);
    w[23 +: 3] = 3'(rphi[i]);
    return w;
  endfunction

  task automatic load_table();
    for (int i = 0; i < NROAD; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_we = 1'b1; ld_addr = AW'(i); ld_road = pack(i);
      @(posedge clk);
    end
    @(negedge clk);
    ld_we = 1'b0; ld_en = 1'b0;
  endtask

  task automatic run_ev(input int fa, input int fl, input bit noisy, output int lat);
    @(negedge clk);
    evt_stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    evt_stb = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      if (fl > 0 && lat == fa) ld_en = 1'b1;
      if (fl > 0 && lat == fa + fl) ld_en = 1'b0;
      if (noisy && lat == 3) begin
        evt_stb = 1'b1; v0 = ~v0; v1 = ~v1; v2 = ~v2; v3 = ~v3;
      end
      if (noisy && lat == 4) evt_stb = 1'b0;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic check_ev(input string tag, input int lat, input int extra);
    chk(lat == NROAD + 2 + extra, {tag, " R7 done latency"}, lat, NROAD + 2 + extra);
    chk(trk_valid == e_v, {tag, " R4/R6 valid"}, trk_valid, e_v);
    chk(int'(trk_pt) == e_pt, {tag, " R4 best pt"}, trk_pt, e_pt);
    chk(int'(trk_phi) == e_phi, {tag, " R4 best phi"}, trk_phi, e_phi);
    chk(int'(trk_road) == e_idx, {tag, " R4 best index"}, trk_road, e_idx);
    chk(int'(trk_count) == e_cnt, {tag, " R5 count"}, trk_count, e_cnt);
  endtask

  task automatic rand_table();
    for (int i = 0; i < NROAD; i++) begin
      for (int k = 0; k < 4; k++) begin
        int r = $urandom % 10;
        rp[i][k] = $urandom % NPIX;
        rs[i][k] = (r < 7) ? r : 7;
      end
      rpt[i]  = $urandom % 8;
      rphi[i] = $urandom % 8;
    end
  endtask

  task automatic rand_vec();
    v0 = 12'($urandom & $urandom & $urandom);
    v1 = 12'($urandom & $urandom & $urandom);
    v2 = 20'($urandom & $urandom & $urandom);
    v3 = 20'($urandom & $urandom & $urandom);
    if ($urandom % 4 != 0) begin
      int r = $urandom % NROAD;
      for (int k = 0; k < 4; k++) begin
        int s = rs[r][k];
        if (s == 7) s = $urandom % nsl(k);
        if (s < nsl(k)) setbit(k, rp[r][k]*nsl(k) + s);
      end
    end
  endtask

  task automatic all_any(input int pix);
    for (int i = 0; i < NROAD; i++) begin
      for (int k = 0; k < 4; k++) begin rp[i][k] = pix; rs[i][k] = 7; end
      rphi[i] = (i + 3) % 8;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat;
    rst = 1'b1; evt_stb = 1'b0; ld_en = 1'b0; ld_we = 1'b0;
    ld_addr = '0; ld_road = '0; v0 = '0; v1 = '0; v2 = '0; v3 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(done == 1'b0, "R11 reset done", done, 0);
    chk(trk_valid == 1'b0, "R11 reset valid", trk_valid, 0);
    chk(trk_count == '0, "R11 reset count", trk_count, 0);
    chk(trk_pt == '0 && trk_road == '0, "R11 reset pt/road", trk_pt, 0);

    // R4 tie break: equal highest codes at 2, 4, 6 -> index 2; R10 table write
    all_any(0);
    rpt = '{1, 5, 6, 3, 6, 2, 6, 4};
    load_table();
    v0 = 12'h1; v1 = 12'h2; v2 = 20'h4; v3 = 20'h10;
    model();
    run_ev(0, 0, 0, lat);
    check_ev("tie R10", lat, 0);

    // R6: nothing fired
    v0 = '0; v1 = '0; v2 = '0; v3 = '0;
    model();
    run_ev(0, 0, 0, lat);
    check_ev("empty R6", lat, 0);

    // R3: every road matches but is below the minimum code
    rpt = '{0, 1, 1, 0, 1, 0, 0, 1};
    load_table();
    v0 = '1; v1 = '1; v2 = '1; v3 = '1;
    model();
    run_ev(0, 0, 0, lat);
    check_ev("floor R3", lat, 0);

    // R2: inner code 3 and outer code 5 cannot match; road 1 should win
    all_any(2);
    rpt = '{7, 3, 6, 0, 0, 0, 0, 0};
    rs[0][1] = 3;
    rs[2][3] = 5;
    load_table();
    model();
    run_ev(0, 0, 0, lat);
    check_ev("slope range R2", lat, 0);
    chk(int'(trk_road) == 1, "R2 out-of-range slope rejected", trk_road, 1);

    // R1: specific slope bin must be the fired one
    rs[1][2] = 1;
    load_table();
    v2 = '0; v2[2*5+3] = 1'b1;
    model();
    run_ev(0, 0, 0, lat);
    check_ev("slope bin R1", lat, 0);
    chk(trk_valid == 1'b0, "R1 wrong slope bin no match", trk_valid, 0);

    // R8: strobe while loading is ignored, outputs hold (R11)
    begin
      int old_cnt = int'(trk_count);
      bit seen = 1'b0;
      @(negedge clk);
      ld_en = 1'b1; evt_stb = 1'b1;
      @(negedge clk);
      evt_stb = 1'b0;
      repeat (12) begin @(negedge clk); if (done) seen = 1'b1; end
      ld_en = 1'b0;
      repeat (14) begin @(negedge clk); if (done) seen = 1'b1; end
      chk(!seen, "R8 strobe under load ignored", seen, 0);
      chk(int'(trk_count) == old_cnt, "R11 outputs held", trk_count, old_cnt);
    end

    // Random sweep with freeze (R9) and busy strobes (R8) mixed in
    for (int t = 0; t < 12; t++) begin
      rand_table();
      load_table();
      for (int e = 0; e < 20; e++) begin
        rand_vec();
        model();
        if (e == 5) begin
          run_ev(3, 4, 0, lat);
          check_ev("freeze R9", lat, 4);
        end else if (e == 9) begin
          run_ev(0, 0, 1, lat);
          check_ev("busy strobe R8", lat, 0);
        end else begin
          run_ev(0, 0, 0, lat);
          check_ev("sweep R1", lat, 0);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule